// File: doc/BRIEF.md
# Port Change Interrupt Generator

This block watches a 16-bit general-purpose port and requests an interrupt when any bit used as an input moves away from a stored reference value. The request is active low on an open-drain line, so the block only produces an enable for the pull-down transistor: a 1 on `irq_pull_en` pulls the shared interrupt line low. A bit counts as an input only while the port's output latch holds 1 for it. Bits latched low are actively driven low by the port, so they are masked.

The raw pin values pass through a synchronizer. They are then compared bit by bit with a reference snapshot. At reset the snapshot holds all ones, which is the port's power-on state. The request stays up while any unmasked bit differs from the snapshot. It drops by itself once the pins return to the snapshot value.

The serial-bus slave next to this block supplies two single-cycle strobes. One marks the acknowledge of a data byte read from this device, timed to the rising clock edge of that acknowledge. The other marks the acknowledge of a data byte written to this device, timed to the falling clock edge. The slave raises neither strobe for traffic addressed to other devices. Either strobe clears the request and reloads the snapshot from the synchronized pins. After that, each new change raises the request again.

Top module: `port_change_irq`

## Requirements
- R1: During and right after reset, `irq_pull_en` is 0 and the snapshot holds all ones, so pins held at all ones never raise the request.
- R2: A falling or rising change on a bit whose `out_latch` bit is 1 sets `irq_pull_en` on the third rising clock edge after the new pin value is first sampled (two synchronizer stages plus one register). It is still 0 after the second edge. The parameter VALID_CYC bounds this delay in cycles.
- R3: A pin bit whose `out_latch` bit is 0 has no effect on `irq_pull_en`, whichever way it moves.
- R4: With no strobe, `irq_pull_en` returns to 0 three edges after the last differing unmasked bit returns to its snapshot value. While any one such bit still differs, it stays 1.
- R5: A cycle with `rd_ack_stb` high clears `irq_pull_en` on that edge and loads the synchronized pin values into the snapshot. The pins left at their new value then keep the request at 0.
- R6: A cycle with `wr_ack_stb` high has the same effect as R5.
- R7: After a clear, a later change of an unmasked bit relative to the reloaded snapshot raises `irq_pull_en` again, including a return to the value held before the clear.
- R8: A change that reaches the synchronizer output on the same edge as a strobe becomes part of the new snapshot and raises no request. A change that reaches it one edge after the strobe is still detected.
- R9: While no strobe occurs and neither the synchronized pins nor the latch move, `irq_pull_en` stays 1 once it is set, however long that lasts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | 16 | Raw port pin levels, asynchronous to clk |
| out_latch | input | 16 | Port output latch; 1 marks a bit usable as an input |
| rd_ack_stb | input | 1 | One-cycle strobe: acknowledge of a data byte read from this device |
| wr_ack_stb | input | 1 | One-cycle strobe: acknowledge of a data byte written to this device |
| irq_pull_en | output | 1 | 1 enables the pull-down on the open-drain interrupt line |

## Verification
Single bits are driven low and back high to show detection in both directions. These tests also check the exact edge of assertion and the release when the pins return. Several bits change together and are restored one at a time, which tells a full return apart from a partial one. Each of the two strobes is applied while the pins stay at their new value, which tells a snapshot reload apart from a plain clear of the request. Toggles on a latched-low bit next to a toggle on its latched-high neighbour show the mask. A strobe placed exactly on, and then one cycle before, the edge where a change leaves the synchronizer shows which changes are absorbed and which survive.

// File: rtl/pcirq_pkg.sv
// Shared constants and helpers for the port change interrupt block.
// Assumes: all ports are packed vectors with bit 0 as the lowest port bit.
package pcirq_pkg;

    // Default width of the watched port.
    localparam int PORT_W_DEF = 16;

    // Default number of synchronizer flops on the pin path.
    localparam int SYNC_DEF = 2;

    // Bits that are inputs (latch 1) and differ from the reference.
    function automatic logic [PORT_W_DEF-1:0] masked_diff(
        input logic [PORT_W_DEF-1:0] cur,
        input logic [PORT_W_DEF-1:0] ref_val,
        input logic [PORT_W_DEF-1:0] latch
    );
        return (cur ^ ref_val) & latch;
    endfunction

endpackage

// File: rtl/pcirq_sync.sv
// Multi-flop synchronizer for the raw port pins.
// What it does: moves the asynchronous pin levels into the clk domain
// through STAGES flops.
// Assumes: each pin bit is synchronized on its own; a skew of one cycle
// between bits is acceptable. Reset loads all ones, the power-on port level.
module pcirq_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_raw,
    output logic [W-1:0] pin_sync
);

    logic [STAGES-1:0][W-1:0] stg_q;

    // Shift the pin sample through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_q <= {STAGES{{W{1'b1}}}};
        end else begin
            stg_q <= {stg_q[STAGES-2:0], pin_raw};
        end
    end

    assign pin_sync = stg_q[STAGES-1];

endmodule

// File: rtl/pcirq_snapshot.sv
// Reference snapshot register.
// What it does: holds the port value that later changes are compared
// against. It is reloaded from the synchronized pins on every clear.
// Assumes: clear is a one-cycle strobe that already merges both clear sources.
module pcirq_snapshot #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic [W-1:0] pin_sync,
    output logic [W-1:0] snap
);

    // Capture the reference at reset (all ones) and on every clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap <= {W{1'b1}};
        end else if (clear) begin
            snap <= pin_sync;
        end
    end

endmodule

// File: rtl/pcirq_detect.sv
// Masked change detector and interrupt request register.
// What it does: raises the request while any latched-high bit differs from
// the snapshot. The request drops on a clear or when the pins return.
// Assumes: snap is reloaded on the same edge that clear is seen.
module pcirq_detect
    import pcirq_pkg::*;
#(
    parameter int W = PORT_W_DEF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic [W-1:0] pin_sync,
    input  logic [W-1:0] snap,
    input  logic [W-1:0] latch,
    output logic         irq
);

    logic [W-1:0] diff;

    // Bits that count as inputs and have moved away from the reference.
    always_comb begin
        diff = (pin_sync ^ snap) & latch;
    end

    // Register the request; a clear wins over any pending difference.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else if (clear) begin
            irq <= 1'b0;
        end else begin
            irq <= |diff;
        end
    end

    // R3: a rising request needs an unmasked difference one cycle earlier.
    a_r3_masked_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(pin_sync & latch) != $past(snap & latch)));

endmodule

// File: rtl/port_change_irq.sv
// Port change interrupt generator, top level.
// What it does: synchronizes the port pins, keeps a reference snapshot and
// drives an open-drain pull-down enable while latched-high bits differ from it.
// Assumes: rd_ack_stb and wr_ack_stb are one-cycle strobes raised only for
// accesses to this device, already aligned to the required bus clock edges.
// out_latch is synchronous to clk.
module port_change_irq
    import pcirq_pkg::*;
#(
    parameter int W          = PORT_W_DEF,
    parameter int SYNC_STG   = SYNC_DEF,
    parameter int VALID_CYC  = SYNC_DEF + 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_in,
    input  logic [W-1:0] out_latch,
    input  logic         rd_ack_stb,
    input  logic         wr_ack_stb,
    output logic         irq_pull_en
);

    localparam int CNT_W = $clog2(VALID_CYC + 1);

    logic [W-1:0] pin_sync;
    logic [W-1:0] snap;
    logic         clear;

    // Either access acknowledge resets the interrupt circuit.
    always_comb begin
        clear = rd_ack_stb | wr_ack_stb;
    end

    pcirq_sync #(.W(W), .STAGES(SYNC_STG)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_raw  (pin_in),
        .pin_sync (pin_sync)
    );

    pcirq_snapshot #(.W(W)) u_snap (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .pin_sync (pin_sync),
        .snap     (snap)
    );

    pcirq_detect #(.W(W)) u_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .pin_sync (pin_sync),
        .snap     (snap),
        .latch    (out_latch),
        .irq      (irq_pull_en)
    );

    // Checker state: cycles that raw pins have held a stable unmasked difference.
    logic [CNT_W-1:0] pend_cnt;

    // Count a steady raw difference; restart on any movement or clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_cnt <= '0;
        end else if (clear || !$stable(pin_in) || !$stable(out_latch) ||
                     (((pin_in ^ snap) & out_latch) == '0)) begin
            pend_cnt <= '0;
        end else if (pend_cnt != CNT_W'(VALID_CYC)) begin
            pend_cnt <= pend_cnt + 1'b1;
        end
    end

    // R2: a steady difference must have raised the request within VALID_CYC.
    a_r2_valid_time: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_cnt == CNT_W'(VALID_CYC)) |-> irq_pull_en);

    // R5: a read acknowledge leaves the request released.
    a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack_stb |=> !irq_pull_en);

    // R6: a write acknowledge leaves the request released.
    a_r6_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ack_stb |=> !irq_pull_en);

    // R9: with nothing moving and no strobe, a raised request is held.
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pull_en && !clear && $stable(pin_sync) && $stable(out_latch))
        |=> irq_pull_en);

endmodule

// File: tb/port_change_irq_test.sv
// Directed bench for port_change_irq: one task per scenario.
module port_change_irq_test;

    localparam int CLK_PERIOD = 10;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [W-1:0] pin_in;
    logic [W-1:0] out_latch;
    logic         rd_ack_stb;
    logic         wr_ack_stb;
    logic         irq_pull_en;

    int checks = 0;
    int errors = 0;

    port_change_irq uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin_in      (pin_in),
        .out_latch   (out_latch),
        .rd_ack_stb  (rd_ack_stb),
        .wr_ack_stb  (wr_ack_stb),
        .irq_pull_en (irq_pull_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input logic exp, input string req);
        checks++;
        if (irq_pull_en !== exp) begin
            errors++;
            $display("FAIL %s: irq_pull_en=%b expected %b at %0t", req, irq_pull_en, exp, $time);
        end
    endtask

    task automatic pulse_rd();
        rd_ack_stb = 1'b1;
        cyc(1);
        rd_ack_stb = 1'b0;
    endtask

    task automatic pulse_wr();
        wr_ack_stb = 1'b1;
        cyc(1);
        wr_ack_stb = 1'b0;
    endtask

    // Let the pins settle, then clear so that snapshot equals the pins.
    task automatic resync();
        cyc(3);
        pulse_wr();
    endtask

    task automatic t_reset();
        rst_n = 1'b0; pin_in = '1; out_latch = '1;
        rd_ack_stb = 1'b0; wr_ack_stb = 1'b0;
        cyc(3);
        chk(1'b0, "R1 during reset");
        rst_n = 1'b1;
        cyc(1);
        chk(1'b0, "R1 after reset");
        cyc(5);
        chk(1'b0, "R1 all-ones pins vs reset snapshot");
    endtask

    task automatic t_fall_and_return();
        pin_in[3] = 1'b0;
        cyc(2);
        chk(1'b0, "R2 not before third edge");
        cyc(1);
        chk(1'b1, "R2 falling edge detected");
        pin_in[3] = 1'b1;
        cyc(2);
        chk(1'b1, "R4 held until return reaches sync");
        cyc(1);
        chk(1'b0, "R4 self release on return");
    endtask

    task automatic t_read_clear();
        pin_in[5] = 1'b0;
        cyc(3);
        chk(1'b1, "R2 change on bit 5");
        pulse_rd();
        chk(1'b0, "R5 read ack clears");
        cyc(5);
        chk(1'b0, "R5 snapshot reloaded");
        pin_in[5] = 1'b1;
        cyc(3);
        chk(1'b1, "R7 rising change after read clear");
        resync();
        chk(1'b0, "R6 resync clear");
    endtask

    task automatic t_write_clear();
        pin_in[12] = 1'b0;
        cyc(3);
        chk(1'b1, "R2 change on bit 12");
        pulse_wr();
        chk(1'b0, "R6 write ack clears");
        cyc(5);
        chk(1'b0, "R6 snapshot reloaded");
        pin_in[12] = 1'b1;
        cyc(3);
        chk(1'b1, "R7 return to old value after write clear");
        resync();
    endtask

    task automatic t_hold();
        pin_in[0] = 1'b0;
        cyc(3);
        cyc(20);
        chk(1'b1, "R9 held with no strobe");
        pin_in[0] = 1'b1;
        cyc(3);
        chk(1'b0, "R4 release after long hold");
    endtask

    task automatic t_mask();
        out_latch[8] = 1'b0;
        cyc(1);
        pin_in[8] = 1'b0;
        cyc(6);
        chk(1'b0, "R3 masked bit falling ignored");
        pin_in[8] = 1'b1;
        cyc(6);
        chk(1'b0, "R3 masked bit rising ignored");
        pin_in[9] = 1'b0;
        cyc(3);
        chk(1'b1, "R3 neighbour bit still detected");
        pin_in[9] = 1'b1;
        cyc(3);
        chk(1'b0, "R4 neighbour returned");
        out_latch = '1;
        cyc(2);
    endtask

    task automatic t_multi();
        pin_in[1] = 1'b0;
        pin_in[14] = 1'b0;
        cyc(3);
        chk(1'b1, "R2 two bits changed");
        pin_in[1] = 1'b1;
        cyc(3);
        chk(1'b1, "R4 partial return keeps request");
        pin_in[14] = 1'b1;
        cyc(3);
        chk(1'b0, "R4 full return releases");
    endtask

    task automatic t_coincide();
        pin_in[7] = 1'b0;
        cyc(2);
        pulse_rd();
        chk(1'b0, "R8 change on clear edge absorbed");
        cyc(5);
        chk(1'b0, "R8 absorbed change stays silent");
        pin_in[7] = 1'b1;
        cyc(3);
        chk(1'b1, "R7 change against absorbed snapshot");
        resync();
        pin_in[7] = 1'b0;
        cyc(1);
        pulse_rd();
        chk(1'b0, "R8 early clear edge");
        cyc(1);
        chk(1'b1, "R8 change one edge after clear detected");
        pin_in[7] = 1'b1;
        cyc(3);
        chk(1'b0, "R4 release after late change");
    endtask

    initial begin
        t_reset();
        t_fall_and_return();
        t_read_clear();
        t_write_clear();
        t_hold();
        t_mask();
        t_multi();
        t_coincide();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not end, actual running expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule